// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a clocked host and an external asynchronous static RAM organised as 2M bytes, 21 address bits by 8 data bits. The host offers one request at a time on a valid/ready handshake: an address, a write flag and a write byte. The controller turns each request into a timed sequence on the memory pins. The memory pins are address, active-low chip select, active-low output enable, active-low write strobe, and a data bus split into outgoing data, incoming data and a driver enable. Read results return on a one-cycle strobe together with the captured byte.

Every phase length is a parameter in clock cycles. These are the address setup before the strobe, the write strobe while the bus is driven, the read access and the idle turnaround after each operation, each at least one cycle. They let one netlist meet the memory's nanosecond limits at any clock rate. Output enable stays high through every write, so the shorter write-strobe minimum applies. The controller's bus drivers switch on only after the memory has let go of the bus, and they switch off one cycle after the strobe rises. Between operations chip select is high, which leaves the memory in standby.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and after a synchronous reset the pins are idle. That means `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the operation and its turnaround end. While it is 0, changes on the request inputs do not affect the pins.
- R3: Pin encoding is fixed. A read drives `mem_ce_n`=0, `mem_we_n`=1 and `mem_oe_n`=0. A write drives `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1. `mem_oe_n` and `mem_we_n` are never 0 in the same cycle.
- R4: Each operation opens with SETUP_CYC cycles in which `mem_ce_n`=0 and the other strobes are 1. `mem_addr` holds the request address without change for as long as `mem_ce_n` stays 0.
- R5: A write holds `mem_we_n` at 0 for WPULSE_CYC+1 cycles. In the first of these cycles the bus is not driven. In the remaining WPULSE_CYC cycles, and in the one cycle after `mem_we_n` returns to 1, `mem_dq_oe` is 1 and `mem_dq_out` carries the write byte. After that cycle `mem_dq_oe` returns to 0.
- R6: A read holds `mem_oe_n` at 0 for RACC_CYC cycles. `mem_dq_in` is sampled on the clock edge that ends this phase. `rd_valid` is 1 for exactly the following cycle, with `rd_data` equal to the sampled byte.
- R7: Every operation ends with TURN_CYC cycles in which `mem_ce_n`=1 and the bus is not driven. `req_ready` returns to 1 in the cycle after these.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0 or `mem_ce_n` is 1.
- R9: A reset in the middle of an operation brings the pins to the idle state of R1 on the next edge.
- R10: A byte written to an address is returned by a later read of that address, including addresses 0 and 2^21-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | DATA_W | Returned read byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
The bench builds the controller with setup 2, write strobe 3, read access 4 and turnaround 1. Because the four lengths differ, a phase that uses the wrong count or the wrong length parameter changes the cycle pattern the bench expects. Multi-cycle phases exercise the shared down-counter beyond a single step, and the one-cycle turnaround puts the read strobe next to the return of ready. A pin-level memory model stores bytes only at the edge that ends the write overlap, and it returns a filler byte unless a read is actually selected. Round trips at both ends of the address range therefore show whether the data was driven in time and whether the sample was taken inside the read window.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WREL,
        ST_WDRV,
        ST_WHOLD,
        ST_RACC,
        ST_TURN
    } ctl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic bus_en;
        logic ready;
    } pin_vec_t;

    function automatic pin_vec_t pins_for(input ctl_state_e s);
        pin_vec_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, bus_en: 1'b0, ready: 1'b0};
        case (s)
            ST_IDLE:  p.ready  = 1'b1;
            ST_SETUP: p.ce_n   = 1'b0;
            ST_WREL: begin
                p.ce_n = 1'b0;
                p.we_n = 1'b0;
            end
            ST_WDRV: begin
                p.ce_n   = 1'b0;
                p.we_n   = 1'b0;
                p.bus_en = 1'b1;
            end
            ST_WHOLD: begin
                p.ce_n   = 1'b0;
                p.bus_en = 1'b1;
            end
            ST_RACC: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            default: p.ce_n = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_rd_capture.sv
module sramc_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (capture) begin
            data_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign dout = data_q;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int WPULSE_CYC = 2,
    parameter int RACC_CYC   = 2,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    // Phase lengths clamped to at least one cycle.
    localparam int S_LEN = (SETUP_CYC  < 1) ? 1 : SETUP_CYC;
    localparam int W_LEN = (WPULSE_CYC < 1) ? 1 : WPULSE_CYC;
    localparam int R_LEN = (RACC_CYC   < 1) ? 1 : RACC_CYC;
    localparam int T_LEN = (TURN_CYC   < 1) ? 1 : TURN_CYC;
    localparam int MAX_SW = (S_LEN > W_LEN) ? S_LEN : W_LEN;
    localparam int MAX_RT = (R_LEN > T_LEN) ? R_LEN : T_LEN;
    localparam int MAXC   = (MAX_SW > MAX_RT) ? MAX_SW : MAX_RT;
    localparam int CNT_W  = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] S_LOAD = CNT_W'(S_LEN - 1);
    localparam logic [CNT_W-1:0] W_LOAD = CNT_W'(W_LEN - 1);
    localparam logic [CNT_W-1:0] R_LOAD = CNT_W'(R_LEN - 1);
    localparam logic [CNT_W-1:0] T_LOAD = CNT_W'(T_LEN - 1);

    typedef struct packed {
        ctl_state_e        state;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        pin_vec_t          pins;
        logic              rd_valid;
    } ctl_regs_t;

    ctl_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap_en;

    sramc_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sramc_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (cap_en),
        .din     (mem_dq_in),
        .dout    (rd_data)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        cap_en       = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state = ST_SETUP;
                    r_d.is_wr = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    tmr_load  = 1'b1;
                    tmr_val   = S_LOAD;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    if (r_q.is_wr) begin
                        r_d.state = ST_WREL;
                    end else begin
                        r_d.state = ST_RACC;
                        tmr_load  = 1'b1;
                        tmr_val   = R_LOAD;
                    end
                end
            end
            ST_WREL: begin
                r_d.state = ST_WDRV;
                tmr_load  = 1'b1;
                tmr_val   = W_LOAD;
            end
            ST_WDRV: begin
                if (tmr_done) begin
                    r_d.state = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                r_d.state = ST_TURN;
                tmr_load  = 1'b1;
                tmr_val   = T_LOAD;
            end
            ST_RACC: begin
                if (tmr_done) begin
                    r_d.state    = ST_TURN;
                    r_d.rd_valid = 1'b1;
                    cap_en       = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = T_LOAD;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.pins = pins_for(r_d.state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state    <= ST_IDLE;
            r_q.is_wr    <= 1'b0;
            r_q.addr     <= '0;
            r_q.wdata    <= '0;
            r_q.pins     <= pins_for(ST_IDLE);
            r_q.rd_valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = r_q.pins.ready;
    assign rd_valid   = r_q.rd_valid;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.pins.ce_n;
    assign mem_oe_n   = r_q.pins.oe_n;
    assign mem_we_n   = r_q.pins.we_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.pins.bus_en;

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    a_r3_no_read_write_overlap: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    a_r5_drive_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_oe);

    a_r5_release_next: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !mem_ce_n) |=> !mem_dq_oe);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $past(req_ready));

    a_r2_ready_means_standby: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r6_after_read_window: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_port_ctrl_test.sv
`timescale 1ns/1ps
module sram_port_ctrl_test;

    localparam int AW = 21;
    localparam int DW = 8;
    localparam int S  = 2;
    localparam int W  = 3;
    localparam int R  = 4;
    localparam int T  = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_port_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S),
        .WPULSE_CYC(W), .RACC_CYC(R), .TURN_CYC(T)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Pin-level memory model: stores on the edge ending the write overlap.
    logic [DW-1:0] pmem [int];
    int            pm_epoch = 0;

    function automatic logic [DW-1:0] pm_read(input int a);
        if (pmem.exists(a)) return pmem[a];
        return '0;
    endfunction

    always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or pm_epoch) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) mem_dq_in = pm_read(int'(mem_addr));
        else                                     mem_dq_in = 8'h5A;
    end

    // Reference model: expected pin vector per cycle.
    // vector bits: {ce_n, oe_n, we_n, dq_oe, ready, rd_valid}
    typedef struct {
        logic [5:0] v;
        string      tag;
    } exp_t;

    exp_t          expq[$];
    logic [DW-1:0] rdq[$];
    logic [DW-1:0] ref_mem [int];
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    bit            started = 0;
    bit            rst_s = 1;
    logic          prev_ce = 1, prev_we = 1, prev_drv = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dq = '0;

    function automatic logic [DW-1:0] ref_read(input int a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic push_n(input int n, input logic [5:0] v, input string tag);
        for (int i = 0; i < n; i++) expq.push_back('{v: v, tag: tag});
    endtask

    always @(posedge clk) begin
        started <= 1;
        rst_s   <= rst;
        if (rst) begin
            expq.delete();
            rdq.delete();
        end else if (req_valid && req_ready) begin
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            push_n(S, 6'b011000, "R4");
            if (req_write) begin
                push_n(1, 6'b010000, "R5");
                push_n(W, 6'b010100, "R5");
                push_n(1, 6'b011100, "R5");
                push_n(T, 6'b111000, "R7");
                ref_mem[int'(req_addr)] = req_wdata;
            end else begin
                push_n(R, 6'b001000, "R6");
                push_n(1, 6'b111001, "R6");
                push_n(T - 1, 6'b111000, "R7");
                rdq.push_back(ref_read(int'(req_addr)));
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            exp_t       e;
            logic [5:0] act;
            act = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid};
            if (rst_s || expq.size() == 0) begin
                e.v   = 6'b111010;
                e.tag = rst_s ? "R9" : "R1";
            end else begin
                e = expq.pop_front();
            end
            check(act == e.v, e.tag, "pin vector", act, e.v);
            if (!rst_s && !mem_ce_n)
                check(mem_addr == cur_addr, "R4", "address", mem_addr, cur_addr);
            if (!rst_s && mem_dq_oe)
                check(mem_dq_out == cur_wdata, "R5", "write data", mem_dq_out, cur_wdata);
            if (!rst_s && rd_valid) begin
                logic [DW-1:0] want;
                want = (rdq.size() != 0) ? rdq.pop_front() : 8'hEE;
                check(rd_data == want, "R10", "read data", rd_data, want);
            end
            // Write ends when either strobe leaves the low-low overlap.
            if (!prev_ce && !prev_we && (mem_ce_n || mem_we_n)) begin
                check(prev_drv == 1'b1, "R5", "data set up before strobe end", prev_drv, 1);
                pmem[int'(prev_addr)] = prev_dq;
                pm_epoch++;
            end
            prev_ce   = mem_ce_n;
            prev_we   = mem_we_n;
            prev_drv  = mem_dq_oe;
            prev_addr = mem_addr;
            prev_dq   = mem_dq_out;
        end
    end

    // Offers a request and holds it until it is taken (R2).
    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk);
        #2;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    bit timed_out = 0;

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #2 rst = 1'b0;
                // R10 boundary addresses and basic round trip
                issue(1'b1, 21'h000000, 8'hA5);
                issue(1'b1, 21'h1FFFFF, 8'h3C);
                issue(1'b0, 21'h000000, 8'h00);
                issue(1'b0, 21'h1FFFFF, 8'h00);
                // R2 back-to-back: held requests wait, inputs change while busy
                issue(1'b1, 21'h012345, 8'h7E);
                issue(1'b0, 21'h012345, 8'h00);
                issue(1'b0, 21'h000100, 8'h00);
                wait_idle();
                // R9 reset during the setup phase of a write
                begin
                    logic [DW-1:0] keep;
                    keep = ref_read(0);
                    issue(1'b1, 21'h000000, 8'hFF);
                    rst = 1'b1;
                    @(posedge clk);
                    @(posedge clk);
                    #2 rst = 1'b0;
                    ref_mem[0] = keep;
                end
                issue(1'b0, 21'h000000, 8'h00);
                issue(1'b1, 21'h0AAAAA, 8'h81);
                issue(1'b0, 21'h0AAAAA, 8'h00);
                issue(1'b0, 21'h1FFFFF, 8'h00);
                wait_idle();
                repeat (4) @(negedge clk);
                check(expq.size() == 0 && rdq.size() == 0, "R6", "pending expectations",
                      expq.size() + rdq.size(), 0);
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule